// File: doc/BRIEF.md
# Lane-Partitioned Signed Saturating Adder

This block adds or subtracts two wide two's-complement words while treating each word as a row of independent signed lanes. A mode input sets the lane width to one, two, four or all eight of the byte-wide segments that make up the 64-bit datapath. One carry chain runs through all the segments. It is broken at every lane boundary, so no carry passes from one lane into the next.

Every lane detects its own signed overflow. A select input chooses what an overflowing lane returns. In wrapping mode it returns the modular result. In saturating mode it returns the extreme value of the sign that the true result would have had. The per-lane overflow flags come out on a byte-aligned flag vector in both modes.

The arithmetic is combinational. A parameter can add one output register, with an asynchronous active-low reset, for timing closure.

Top module: `simd_sat_adder`

## Requirements
- R1: `mode_i` sets the lane width. Value 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes and 3 gives one 64-bit lane. Lane n occupies bits [n*W+W-1 : n*W].
- R2: No carry passes from one lane into the next. Each lane's result depends only on that lane's bits of `a_i` and `b_i`.
- R3: With `sub_i`=1, each lane computes a minus b as a plus the bitwise inverse of b plus one. The carry-in of every lane is therefore 1.
- R4: For an add, a lane overflows exactly when both operands have the same sign and the result sign differs from it. Operands of opposite sign never overflow.
- R5: For a subtract, a lane overflows exactly when the operand signs differ and the result sign differs from the sign of a.
- R6: With `sat_i`=0, every lane returns its result modulo 2^W, including lanes that overflow.
- R7: With `sat_i`=1, a lane that overflows toward the positive side returns 0x7F..F, the largest positive value of its width.
- R8: With `sat_i`=1, a lane that overflows toward the negative side returns 0x80..0, the most negative value of its width.
- R9: `ovf_o` bit k is 1 only when byte k is the most significant byte of a lane and that lane overflowed. All other bits are 0. The flags are reported whatever the value of `sat_i`.
- R10: With REG_OUT=1, `sum_o` and `ovf_o` show the result of the inputs at the previous rising clock edge. While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode_i | input | 2 | Lane width select (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 64-bit) |
| sub_i | input | 1 | 1 = subtract b from a, 0 = add |
| sat_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| sum_o | output | 64 | Per-lane result |
| ovf_o | output | 8 | Per-lane overflow flags at each lane's top byte |

## Verification
The bench builds the block with its defaults: 8-bit segments, eight segments and the output register enabled. These values make all four lane widths reachable from one instance, and the registered path and the reset state become observable at the ports. A bench-side lane model works on sign-extended integers and compares results against the range limits. It covers a vector table and a long pseudo-random sweep over every combination of mode, add/subtract and wrap/saturate. Directed cases then target the clamp values, carries that stop at a lane edge, and opposite-sign adds.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  // Number of segments per lane is 2**lg; a segment starts a lane when its
  // index is a multiple of that count.
  function automatic logic lane_start(input int k, input int lg);
    return (k & ((1 << lg) - 1)) == 0;
  endfunction

  function automatic int lane_top_idx(input int k, input int lg);
    return k | ((1 << lg) - 1);
  endfunction

  function automatic logic lane_top(input int k, input int lg);
    return lane_top_idx(k, lg) == k;
  endfunction

  // Signed overflow from the operand and result sign bits (b already inverted
  // for subtraction).
  function automatic logic sign_ovf(input logic sa, input logic sb_eff, input logic sr);
    return (sa == sb_eff) && (sr != sa);
  endfunction

endpackage

// File: rtl/sas_segment.sv
module sas_segment
  import simd_add_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_cand_o
);
  localparam int MSB = SEG_W - 1;

  logic [SEG_W-1:0] b_eff;

  always_comb begin
    b_eff = b_i ^ {SEG_W{sub_i}};
    {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin_i};
    ovf_cand_o = sign_ovf(a_i[MSB], b_eff[MSB], sum_o[MSB]);
  end
endmodule

// File: rtl/sas_clamp.sv
module sas_clamp #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] wrap_i,
  input  logic             sat_i,
  input  logic             lane_ovf_i,
  input  logic             lane_neg_i,
  input  logic             is_top_i,
  output logic [SEG_W-1:0] res_o
);
  localparam logic [SEG_W-1:0] POS_TOP = {1'b0, {(SEG_W-1){1'b1}}};
  localparam logic [SEG_W-1:0] NEG_TOP = {1'b1, {(SEG_W-1){1'b0}}};

  logic [SEG_W-1:0] sat_val;

  always_comb begin
    if (is_top_i) sat_val = lane_neg_i ? NEG_TOP : POS_TOP;
    else          sat_val = lane_neg_i ? '0 : '1;
    res_o = (sat_i && lane_ovf_i) ? sat_val : wrap_i;
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = SEG_W * NUM_SEG,
  localparam int MODE_W = $clog2($clog2(NUM_SEG) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sub_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NUM_SEG-1:0] ovf_o
);
  logic [NUM_SEG-1:0] cin_w, cout_w, ovf_cand_w;
  logic [NUM_SEG-1:0] start_w, top_w, lane_ovf_w, lane_neg_w;
  logic [NUM_SEG-1:0] ovf_nx;
  logic [DATA_W-1:0]  wrap_w, res_w;

  // Lane geometry and broadcast of each lane's top-segment status
  always_comb begin
    for (int k = 0; k < NUM_SEG; k++) begin
      int t;
      t = lane_top_idx(k, int'(mode_i));
      start_w[k]    = lane_start(k, int'(mode_i));
      top_w[k]      = lane_top(k, int'(mode_i));
      lane_ovf_w[k] = ovf_cand_w[t];
      lane_neg_w[k] = a_i[t*SEG_W + SEG_W - 1];
      ovf_nx[k]     = top_w[k] & ovf_cand_w[k];
    end
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    if (g == 0) begin : g_first
      assign cin_w[g] = sub_i;
    end else begin : g_rest
      assign cin_w[g] = start_w[g] ? sub_i : cout_w[g-1];
    end

    sas_segment #(.SEG_W(SEG_W)) u_seg (
      .a_i        (a_i[g*SEG_W +: SEG_W]),
      .b_i        (b_i[g*SEG_W +: SEG_W]),
      .sub_i      (sub_i),
      .cin_i      (cin_w[g]),
      .sum_o      (wrap_w[g*SEG_W +: SEG_W]),
      .cout_o     (cout_w[g]),
      .ovf_cand_o (ovf_cand_w[g])
    );

    sas_clamp #(.SEG_W(SEG_W)) u_clamp (
      .wrap_i     (wrap_w[g*SEG_W +: SEG_W]),
      .sat_i      (sat_i),
      .lane_ovf_i (lane_ovf_w[g]),
      .lane_neg_i (lane_neg_w[g]),
      .is_top_i   (top_w[g]),
      .res_o      (res_w[g*SEG_W +: SEG_W])
    );

    // R4
    add_opposite_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_i && (a_i[g*SEG_W+SEG_W-1] != b_i[g*SEG_W+SEG_W-1])) |-> !ovf_cand_w[g]);

    // R5
    sub_same_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_i && (a_i[g*SEG_W+SEG_W-1] == b_i[g*SEG_W+SEG_W-1])) |-> !ovf_cand_w[g]);

    // R7
    sat_pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_i && ovf_nx[g] && !a_i[g*SEG_W+SEG_W-1])
        |-> (res_w[g*SEG_W +: SEG_W] == {1'b0, {(SEG_W-1){1'b1}}}));

    // R8
    sat_neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_i && ovf_nx[g] && a_i[g*SEG_W+SEG_W-1])
        |-> (res_w[g*SEG_W +: SEG_W] == {1'b1, {(SEG_W-1){1'b0}}}));

    if (g > 0) begin : g_cut
      // R2
      lane_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w[g] |-> (cin_w[g] == sub_i));
    end
  end

  // R6
  wrap_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_i |-> (res_w == wrap_w));

  // R9
  ovf_only_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_nx & ~top_w) == '0);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_o <= '0;
        ovf_o <= '0;
      end else begin
        sum_o <= res_w;
        ovf_o <= ovf_nx;
      end
    end

    // R10
    out_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sum_o == $past(res_w)) && (ovf_o == $past(ovf_nx)));
  end else begin : g_comb
    assign sum_o = res_w;
    assign ovf_o = ovf_nx;
  end
endmodule

// File: tb/simd_sat_adder_bench.sv
`timescale 1ns/1ps
module simd_sat_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        sub_i = 1'b0;
  logic        sat_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] sum_o;
  logic [7:0]  ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_sat_adder u_simd_sat_adder (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sub_i(sub_i), .sat_i(sat_i),
    .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .ovf_o(ovf_o)
  );

  // {mode, sub, sat, a, b}
  localparam logic [131:0] VEC [14] = '{
    {2'd0, 1'b0, 1'b1, 64'h7F7F_8080_0102_FF01, 64'h0101_FFFF_0304_0101},
    {2'd0, 1'b0, 1'b0, 64'h7F7F_8080_0102_FF01, 64'h0101_FFFF_0304_0101},
    {2'd0, 1'b1, 1'b1, 64'h8000_7F7F_0000_1234, 64'h0102_FF80_0180_5678},
    {2'd0, 1'b1, 1'b0, 64'h8000_7F7F_0000_1234, 64'h0102_FF80_0180_5678},
    {2'd1, 1'b0, 1'b1, 64'h7FFF_8000_1234_7FFF, 64'h0001_8000_4321_8000},
    {2'd1, 1'b1, 1'b0, 64'h7FFF_8000_1234_7FFF, 64'h8000_0001_4321_FFFF},
    {2'd2, 1'b0, 1'b1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF},
    {2'd2, 1'b1, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF},
    {2'd3, 1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'd3, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {2'd3, 1'b0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'd0, 1'b0, 1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001},
    {2'd1, 1'b0, 1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001},
    {2'd2, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001}
  };

  // Lane model: sign-extend, compute exactly, compare against range limits
  function automatic logic [71:0] model(input logic [1:0] m, input logic s,
                                        input logic st, input logic [63:0] a,
                                        input logic [63:0] b);
    int lw;
    logic [63:0] r;
    logic [7:0] f;
    lw = 8 << m;
    r = '0;
    f = '0;
    for (int l = 0; l < 64 / lw; l++) begin
      logic signed [65:0] va, vb, vr, mx, mn;
      bit ov;
      for (int i = 0; i < 66; i++) begin
        va[i] = (i < lw) ? a[l*lw+i] : a[l*lw+lw-1];
        vb[i] = (i < lw) ? b[l*lw+i] : b[l*lw+lw-1];
      end
      vr = s ? va - vb : va + vb;
      mx = (66'sd1 <<< (lw - 1)) - 66'sd1;
      mn = -(66'sd1 <<< (lw - 1));
      ov = (vr > mx) || (vr < mn);
      if (st && ov) vr = (vr > mx) ? mx : mn;
      for (int i = 0; i < lw; i++) r[l*lw+i] = vr[i];
      f[(l*lw+lw-1)/8] = ov;
    end
    return {f, r};
  endfunction

  task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  // Drive on a falling edge; the register captures on the next rising edge;
  // sample on the falling edge after that.
  task automatic run(input logic [1:0] m, input logic s, input logic st,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic [63:0] exp_sum, input logic [7:0] exp_ovf,
                     input string rq);
    @(negedge clk);
    mode_i = m; sub_i = s; sat_i = st; a_i = a; b_i = b;
    @(negedge clk);
    check({rq, " sum"}, sum_o, exp_sum);
    check({rq, " ovf"}, {56'd0, ovf_o}, {56'd0, exp_ovf});
  endtask

  task automatic run_model(input logic [1:0] m, input logic s, input logic st,
                           input logic [63:0] a, input logic [63:0] b, input string rq);
    logic [71:0] e;
    e = model(m, s, st, a, b);
    run(m, s, st, a, b, e[63:0], e[71:64], rq);
  endtask

  initial begin
    logic [63:0] rs;
    // R10: reset state
    #12;
    check("R10 reset sum", sum_o, 64'd0);
    check("R10 reset ovf", {56'd0, ovf_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R4 R5 R6 R7 R8 R9: vector table against lane model
    for (int i = 0; i < 14; i++) begin
      run_model(VEC[i][131:130], VEC[i][129], VEC[i][128],
                VEC[i][127:64], VEC[i][63:0], "R1/R6 table");
    end

    // Pseudo-random sweep over every mode/op/sat combination
    rs = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 256; i++) begin
      logic [63:0] ra, rb;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
      ra = rs;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
      rb = rs;
      run_model(2'(i % 4), 1'((i / 4) % 2), 1'((i / 8) % 2), ra, rb, "R4/R5 sweep");
    end

    // Directed corner cases
    run(2'd0, 1'b0, 1'b1, 64'h7F, 64'h01, 64'h7F, 8'h01, "R7 byte pos clamp");
    run(2'd0, 1'b1, 1'b1, 64'h80, 64'h01, 64'h80, 8'h01, "R8 byte neg clamp");
    run(2'd1, 1'b0, 1'b0, 64'h7FFF, 64'h1, 64'h8000, 8'h02, "R9 half wrap flag");
    run(2'd3, 1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1,
        64'h7FFF_FFFF_FFFF_FFFF, 8'h80, "R7 dword clamp");
    run(2'd0, 1'b0, 1'b0, 64'hFF, 64'h01, 64'h00, 8'h00, "R2 byte carry cut");
    run(2'd1, 1'b0, 1'b0, 64'hFF, 64'h01, 64'h100, 8'h00, "R1 half carry joins");
    run(2'd0, 1'b0, 1'b1, 64'h80, 64'h7F, 64'hFF, 8'h00, "R4 opposite signs");
    run(2'd2, 1'b1, 1'b1, 64'h0, 64'h8000_0000, 64'h7FFF_FFFF, 8'h08, "R5 sub clamp");
    run(2'd0, 1'b1, 1'b0, 64'h0, 64'h0101_0101_0101_0101,
        64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R3 per-lane carry-in");

    // R10: asynchronous reset clears a nonzero output
    #2;
    rst_n = 1'b0;
    #1;
    check("R10 async reset sum", sum_o, 64'd0);
    check("R10 async reset ovf", {56'd0, ovf_o}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule